// File: doc/BRIEF.md
# Three-State PWM Non-Overlap Sequencer

This block drives the high-side and low-side gate-enable outputs of a synchronous buck power stage. Its control inputs are an enable line and a PWM line. Each one arrives already sorted by external comparators into one of three levels and is carried as a 2-bit code: `00` low, `01` mid, `10` high, and `11` also treated as mid. Two feedback flags come back from the gates. One reports that the low-side gate has discharged. The other reports that the high-side gate, measured against the switch node, has discharged. A supply-good flag gates all activity.

The block never lets both outputs be on at the same time. When PWM changes direction, the output that was on is released after a turn-off propagation delay. The opposite output may turn on only after the released gate's feedback flag has stayed asserted for a full non-overlap interval. A mid level on either input forces both outputs off. After enable rises with the supply good, a start-up blanking interval holds both outputs off and ignores PWM. All delays are parameters counted in clock cycles: `TPD_OFF`, `NOV_DLY` and `STARTUP_DLY`.

The control inputs are plain level signals, not a data stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `tri_pwm_sequencer`

## Requirements
- R1: While enable is low (`00`), both outputs are low regardless of PWM; both are low out of reset.
- R2: While enable is mid (`01` or `11`), both outputs are low for every PWM code.
- R3: Once operating, a steady PWM low turns on only the low-side output, and a steady PWM high turns on only the high-side output.
- R4: The high-side and low-side outputs are never high in the same cycle.
- R5: On PWM going high, the low-side output drops after `TPD_OFF` cycles. The high-side output rises only after the low-side feedback flag has been asserted for `NOV_DLY` consecutive cycles.
- R6: On PWM going low, the high-side output drops after `TPD_OFF` cycles. The low-side output rises only after the high-side feedback flag has been asserted for `NOV_DLY` consecutive cycles.
- R7: PWM mid (`01`) turns both outputs off from the next cycle. After `NOV_DLY` cycles, a PWM that is still mid keeps both off. A PWM that has left mid follows the feedback-and-delay rule of R5/R6.
- R8: After enable becomes high with the supply good, both outputs stay low and PWM is ignored for `STARTUP_DLY` cycles.
- R9: Losing supply-good drops both outputs in the same cycle. When supply-good returns, the `STARTUP_DLY` blanking starts over.
- R10: If PWM returns to the level it just left before the opposite output turns on, the change is cancelled. If the released output has not yet dropped, it stays on. If it has dropped, it turns back on only after its opposite gate's feedback has held for `NOV_DLY` cycles.
- R11: PWM code `11` is handled exactly like mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_lvl | input | 2 | Enable level code (00 low, 01/11 mid, 10 high) |
| pwm_lvl | input | 2 | PWM level code (00 low, 01/11 mid, 10 high) |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| ls_gate_low | input | 1 | Low-side gate has fallen below the discharge threshold |
| hs_gate_low | input | 1 | High-side gate relative to the switch node has fallen below the threshold |
| hs_on | output | 1 | High-side gate drive enable |
| ls_on | output | 1 | Low-side gate drive enable |

## Verification
Two functions can land in the same cycle: a supply-good loss and a PWM transition. When they coincide, the supply loss must win at once. The bench provokes this by dropping supply-good and raising PWM on the same clock edge, then checks that both outputs are already low in that cycle. It also checks that, after supply-good returns with PWM still high, the high-side output waits at least the full blanking interval before it rises. A second overlap is a PWM reversal that arrives while a non-overlap count is running. It is provoked in both the propagation phase and the feedback-wait phase. The scoreboard judges it by which output transitions actually appear.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  typedef enum logic [2:0] {
    S_OFF,
    S_LS_ON,
    S_LS_TOFF,
    S_WAIT_HS,
    S_HS_ON,
    S_HS_TOFF,
    S_WAIT_LS,
    S_MID
  } seq_state_e;
endpackage

// File: rtl/tps_startup_blank.sv
module tps_startup_blank #(
  parameter int STARTUP_DLY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic done
);
  localparam int CW = $clog2(STARTUP_DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STARTUP_DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = arm && (cnt == LIMIT);
endmodule

// File: rtl/tps_nov_fsm.sv
module tps_nov_fsm
  import tps_pkg::*;
#(
  parameter int TPD_OFF = 2,
  parameter int NOV_DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic [1:0] pwm_lvl,
  input  logic       ls_fb,
  input  logic       hs_fb,
  output logic       hs_on,
  output logic       ls_on
);
  localparam int MAXD = (TPD_OFF > NOV_DLY) ? TPD_OFF : NOV_DLY;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] TPD_LAST = CW'(TPD_OFF - 1);
  localparam logic [CW-1:0] NOV_LAST = CW'(NOV_DLY - 1);

  seq_state_e st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic p_hi, p_lo, p_mid;

  assign p_hi  = (pwm_lvl == LVL_HIGH);
  assign p_lo  = (pwm_lvl == LVL_LOW);
  assign p_mid = !p_hi && !p_lo;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (!ready) begin
      st_n  = S_OFF;
      cnt_n = '0;
    end else begin
      unique case (st)
        S_OFF: begin
          if (p_hi)      begin st_n = S_WAIT_HS; cnt_n = '0; end
          else if (p_lo) begin st_n = S_WAIT_LS; cnt_n = '0; end
        end
        S_LS_ON: begin
          if (p_hi)       begin st_n = S_LS_TOFF; cnt_n = '0; end
          else if (p_mid) begin st_n = S_MID;     cnt_n = '0; end
        end
        S_HS_ON: begin
          if (p_lo)       begin st_n = S_HS_TOFF; cnt_n = '0; end
          else if (p_mid) begin st_n = S_MID;     cnt_n = '0; end
        end
        S_LS_TOFF: begin
          if (p_lo)                 begin st_n = S_LS_ON;   cnt_n = '0; end
          else if (p_mid)           begin st_n = S_MID;     cnt_n = '0; end
          else if (cnt == TPD_LAST) begin st_n = S_WAIT_HS; cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
        S_HS_TOFF: begin
          if (p_hi)                 begin st_n = S_HS_ON;   cnt_n = '0; end
          else if (p_mid)           begin st_n = S_MID;     cnt_n = '0; end
          else if (cnt == TPD_LAST) begin st_n = S_WAIT_LS; cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
        S_WAIT_HS: begin
          if (p_lo)                 begin st_n = S_WAIT_LS; cnt_n = '0; end
          else if (p_mid)           begin st_n = S_MID;     cnt_n = '0; end
          else if (!ls_fb)          cnt_n = '0;
          else if (cnt == NOV_LAST) begin st_n = S_HS_ON;   cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
        S_WAIT_LS: begin
          if (p_hi)                 begin st_n = S_WAIT_HS; cnt_n = '0; end
          else if (p_mid)           begin st_n = S_MID;     cnt_n = '0; end
          else if (!hs_fb)          cnt_n = '0;
          else if (cnt == NOV_LAST) begin st_n = S_LS_ON;   cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
        S_MID: begin
          if (cnt == NOV_LAST) begin
            cnt_n = '0;
            if (p_hi)      st_n = S_WAIT_HS;
            else if (p_lo) st_n = S_WAIT_LS;
            else           st_n = S_OFF;
          end else cnt_n = cnt + 1'b1;
        end
        default: begin st_n = S_OFF; cnt_n = '0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign hs_on = ready && ((st == S_HS_ON) || (st == S_HS_TOFF));
  assign ls_on = ready && ((st == S_LS_ON) || (st == S_LS_TOFF));
endmodule

// File: rtl/tri_pwm_sequencer.sv
module tri_pwm_sequencer
  import tps_pkg::*;
#(
  parameter int TPD_OFF     = 2,
  parameter int NOV_DLY     = 3,
  parameter int STARTUP_DLY = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en_lvl,
  input  logic [1:0] pwm_lvl,
  input  logic       supply_ok,
  input  logic       ls_gate_low,
  input  logic       hs_gate_low,
  output logic       hs_on,
  output logic       ls_on
);
  logic en_hi, blank_arm, blank_done, ready;

  assign en_hi     = (en_lvl == LVL_HIGH);
  assign blank_arm = en_hi && supply_ok;
  assign ready     = blank_arm && blank_done;

  tps_startup_blank #(.STARTUP_DLY(STARTUP_DLY)) u_blank (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (blank_arm),
    .done (blank_done)
  );

  tps_nov_fsm #(.TPD_OFF(TPD_OFF), .NOV_DLY(NOV_DLY)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (ready),
    .pwm_lvl(pwm_lvl),
    .ls_fb  (ls_gate_low),
    .hs_fb  (hs_gate_low),
    .hs_on  (hs_on),
    .ls_on  (ls_on)
  );
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] en_lvl,
  input logic [1:0] pwm_lvl,
  input logic       supply_ok,
  input logic       ls_gate_low,
  input logic       hs_gate_low,
  input logic       ready,
  input logic       hs_on,
  input logic       ls_on
);
  assert_never_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  assert_en_low_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lvl == 2'b00) |-> (!hs_on && !ls_on));

  assert_en_mid_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lvl[0] == 1'b1) |-> (!hs_on && !ls_on));

  assert_hs_after_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(ls_gate_low));

  assert_ls_after_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> $past(hs_gate_low));

  assert_mid_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pwm_lvl == 2'b01) |=> (!hs_on && !ls_on));

  assert_alt_mid_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pwm_lvl == 2'b11) |=> (!hs_on && !ls_on));

  assert_blank_on_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_lvl == 2'b10) |-> (!hs_on && !ls_on));

  assert_supply_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!hs_on && !ls_on));
endmodule

bind tri_pwm_sequencer tps_checker u_tps_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_lvl     (en_lvl),
  .pwm_lvl    (pwm_lvl),
  .supply_ok  (supply_ok),
  .ls_gate_low(ls_gate_low),
  .hs_gate_low(hs_gate_low),
  .ready      (ready),
  .hs_on      (hs_on),
  .ls_on      (ls_on)
);

// File: tb/test_tri_pwm_sequencer.sv
module test_tri_pwm_sequencer;
  localparam int TPD     = 2;
  localparam int NOV     = 3;
  localparam int STARTUP = 20;
  localparam int FB_LAG  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] en_lvl, pwm_lvl;
  logic supply_ok, ls_gate_low, hs_gate_low, hs_on, ls_on;
  logic [FB_LAG-1:0] ls_pipe, hs_pipe;

  always #4 clk = ~clk;

  tri_pwm_sequencer #(.TPD_OFF(TPD), .NOV_DLY(NOV), .STARTUP_DLY(STARTUP)) i_tri_pwm_sequencer (
    .clk(clk), .rst_n(rst_n), .en_lvl(en_lvl), .pwm_lvl(pwm_lvl),
    .supply_ok(supply_ok), .ls_gate_low(ls_gate_low), .hs_gate_low(hs_gate_low),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  // Gate discharge model: feedback flag follows the output low with a lag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_pipe <= '1;
      hs_pipe <= '1;
    end else begin
      ls_pipe <= {ls_pipe[FB_LAG-2:0], !ls_on};
      hs_pipe <= {hs_pipe[FB_LAG-2:0], !hs_on};
    end
  end
  assign ls_gate_low = ls_pipe[FB_LAG-1];
  assign hs_gate_low = hs_pipe[FB_LAG-1];

  typedef struct {
    logic [1:0] v;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit both_seen = 1'b0;
  bit gap_chk_hs = 1'b0;
  bit gap_chk_ls = 1'b0;
  int t_ls_fall = 0;
  int t_hs_fall = 0;
  logic [1:0] prev_out = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [1:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic [1:0] en, input logic [1:0] pwm, input logic sup);
    @(posedge clk);
    #1;
    en_lvl = en;
    pwm_lvl = pwm;
    supply_ok = sup;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Monitor: pops the scoreboard on every change of {hs_on, ls_on}.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] cur;
      cur = {hs_on, ls_on};
      if (hs_on && ls_on) both_seen = 1'b1;
      if (cur != prev_out) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected output change R10", int'(cur), int'(prev_out));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cur == e.v, e.tag, int'(cur), int'(e.v));
        end
        if (prev_out[0] && !cur[0]) t_ls_fall = cyc;
        if (prev_out[1] && !cur[1]) t_hs_fall = cyc;
        if (!prev_out[1] && cur[1] && gap_chk_hs) begin
          check((cyc - t_ls_fall >= FB_LAG + NOV) && (cyc - t_ls_fall <= FB_LAG + NOV + 2),
                "R5 dead time ls-off to hs-on", cyc - t_ls_fall, FB_LAG + NOV);
          gap_chk_hs = 1'b0;
        end
        if (!prev_out[0] && cur[0] && gap_chk_ls) begin
          check((cyc - t_hs_fall >= FB_LAG + NOV) && (cyc - t_hs_fall <= FB_LAG + NOV + 2),
                "R6 dead time hs-off to ls-on", cyc - t_hs_fall, FB_LAG + NOV);
          gap_chk_ls = 1'b0;
        end
        prev_out = cur;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en_lvl = 2'b00;
    pwm_lvl = 2'b00;
    supply_ok = 1'b1;
    idle(3);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({hs_on, ls_on} == 2'b00, "R1 reset state", int'({hs_on, ls_on}), 0);

    // R8: blanking after enable, then R3 low-side on for PWM low
    begin
      bit early = 1'b0;
      push(2'b01, "R3 low-side on with PWM low");
      drive(2'b10, 2'b00, 1'b1);
      for (int i = 0; i < STARTUP; i++) begin
        @(negedge clk);
        if (hs_on || ls_on) early = 1'b1;
      end
      check(!early, "R8 outputs held off during blanking", int'(early), 0);
    end
    idle(NOV + FB_LAG + 10);
    @(negedge clk);
    check(ls_on && !hs_on, "R3 steady PWM low", int'({hs_on, ls_on}), 1);

    // R5: rise to high
    gap_chk_hs = 1'b1;
    push(2'b00, "R5 low-side released");
    push(2'b10, "R5 high-side on");
    drive(2'b10, 2'b10, 1'b1);
    idle(30);
    @(negedge clk);
    check(hs_on && !ls_on, "R3 steady PWM high", int'({hs_on, ls_on}), 2);

    // R6: fall to low
    gap_chk_ls = 1'b1;
    push(2'b00, "R6 high-side released");
    push(2'b01, "R6 low-side on");
    drive(2'b10, 2'b00, 1'b1);
    idle(30);

    // R7: mid from low-side on, then leave to high
    push(2'b00, "R7 mid forces both off");
    drive(2'b10, 2'b01, 1'b1);
    idle(15);
    @(negedge clk);
    check({hs_on, ls_on} == 2'b00, "R7 stays off while mid", int'({hs_on, ls_on}), 0);
    push(2'b10, "R7 leaves mid to high");
    drive(2'b10, 2'b10, 1'b1);
    idle(30);

    // R11: code 11 acts as mid
    push(2'b00, "R11 code 11 forces both off");
    drive(2'b10, 2'b11, 1'b1);
    idle(15);
    @(negedge clk);
    check({hs_on, ls_on} == 2'b00, "R11 stays off on code 11", int'({hs_on, ls_on}), 0);
    push(2'b01, "R11 leaves to low");
    drive(2'b10, 2'b00, 1'b1);
    idle(30);

    // R10: reversal during propagation phase, no output change expected
    drive(2'b10, 2'b10, 1'b1);
    drive(2'b10, 2'b00, 1'b1);
    idle(20);
    @(negedge clk);
    check(ls_on && !hs_on, "R10 cancel in propagation phase", int'({hs_on, ls_on}), 1);

    // R10: reversal during feedback wait
    push(2'b00, "R10 low-side released");
    push(2'b01, "R10 low-side restored");
    drive(2'b10, 2'b10, 1'b1);
    for (int i = 0; i < 20 && ls_on; i++) @(negedge clk);
    drive(2'b10, 2'b00, 1'b1);
    idle(30);
    @(negedge clk);
    check(ls_on && !hs_on, "R10 cancel in wait phase", int'({hs_on, ls_on}), 1);

    // R2: enable mid
    push(2'b00, "R2 enable mid forces off");
    drive(2'b01, 2'b00, 1'b1);
    idle(10);
    @(negedge clk);
    check({hs_on, ls_on} == 2'b00, "R2 off while enable mid", int'({hs_on, ls_on}), 0);
    push(2'b01, "R8 restart after enable mid");
    drive(2'b10, 2'b00, 1'b1);
    idle(STARTUP + 30);

    // R9: supply loss in the same cycle as a PWM rise
    begin
      int t0;
      push(2'b00, "R9 supply loss drops outputs");
      drive(2'b10, 2'b10, 1'b0);
      @(negedge clk);
      check({hs_on, ls_on} == 2'b00, "R9 same-cycle supply loss", int'({hs_on, ls_on}), 0);
      idle(10);
      push(2'b10, "R9 high-side after restart");
      drive(2'b10, 2'b10, 1'b1);
      t0 = cyc;
      for (int i = 0; i < STARTUP + 40 && !hs_on; i++) @(negedge clk);
      check(hs_on && (cyc - t0 >= STARTUP), "R9 blanking restarted", cyc - t0, STARTUP);
    end
    idle(10);

    // R1: enable low
    push(2'b00, "R1 enable low forces off");
    drive(2'b00, 2'b10, 1'b1);
    idle(10);
    @(negedge clk);
    check({hs_on, ls_on} == 2'b00, "R1 off while enable low", int'({hs_on, ls_on}), 0);

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    check(!both_seen, "R4 outputs never both high", int'(both_seen), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule